// File: doc/BRIEF.md
# Multi-Level Page Table Walker

This block turns a 39-bit virtual address into a physical page number. It reads page table entries from memory, one level at a time. A walk starts at the first-level table, whose physical address is held in a base register input. The upper nine bits of the virtual page number pick the entry in that table. Each entry that points onward names the page that holds the next table, and the next nine bits of the virtual address select the entry inside it. The lowest 12 address bits are the page offset and take no part in the walk.

The walk stops as soon as it reads a leaf entry. A leaf in the first-level table maps a 1 GB page, a leaf in the second level maps a 2 MB page, and a leaf in the third level maps a 4 KB page. For the two large sizes, the virtual index bits below the leaf pass straight into the physical page number. An entry that is not valid ends the walk with a fault, and so does a pointer entry found at the third level.

The block takes one request at a time. Memory reads and their responses each use a valid/ready handshake, and only one read is in flight at any moment.

Top module: `pt_walker`

## Requirements
- R1: After reset, req_ready_o is 1 and both mem_req_valid_o and rsp_valid_o are 0.
- R2: The first read goes to the address base_i with bits [11:0] cleared, plus 8 times VA[38:30]. The low 12 bits of base_i are ignored.
- R3: Each later read goes to (entry bits [53:10] shifted left by 12) plus 8 times the next index. The second read uses VA[29:21] and the third uses VA[20:12]. A read is issued only after the response to the previous read, there are at most three reads per walk, and mem_req_valid_o and mem_req_addr_o stay stable until mem_req_ready_i is seen.
- R4: Entry layout: bit 0 is valid and bits 1, 2 and 3 are read, write and execute permission. An entry is a leaf when any of bits 1 to 3 is set. Bits [53:10] hold the page number and bits [9:0] are returned on rsp_attr_o.
- R5: A leaf at the third level gives rsp_size_o = 0 and rsp_ppn_o equal to the entry's page number, after exactly 3 reads.
- R6: A leaf at the second level gives rsp_size_o = 1 and rsp_ppn_o equal to the entry's page number with bits [8:0] replaced by VA[20:12], after exactly 2 reads.
- R7: A leaf at the first level gives rsp_size_o = 2 and rsp_ppn_o equal to the entry's page number with bits [17:0] replaced by VA[29:12], after exactly 1 read.
- R8: An entry whose bit 0 is clear, at any level, ends the walk at once. The response has rsp_fault_o = 1 and rsp_ppn_o = 0, and no further read is made.
- R9: A valid pointer entry (bits 1 to 3 all clear) read at the third level ends the walk with rsp_fault_o = 1 after 3 reads.
- R10: req_ready_o is 0 from the cycle after a request is accepted until the response handshake completes. A request presented during that time is not taken.
- R11: While rsp_valid_o is 1 and rsp_ready_i is 0, the response outputs hold their values.
- R12: VA[11:0] changes neither the reads nor the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Walk request valid |
| req_ready_o | output | 1 | Walker idle and able to take a request |
| req_va_i | input | 39 | Virtual address to translate |
| base_i | input | 56 | Physical address of the first-level table |
| mem_req_valid_o | output | 1 | Entry read request valid |
| mem_req_ready_i | input | 1 | Memory accepts the read |
| mem_req_addr_o | output | 56 | Physical address of the entry to read |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_ready_o | output | 1 | Walker is waiting for read data |
| mem_rsp_data_i | input | 64 | Page table entry read from memory |
| rsp_valid_o | output | 1 | Translation result valid |
| rsp_ready_i | input | 1 | Consumer takes the result |
| rsp_fault_o | output | 1 | The walk ended in a page fault |
| rsp_ppn_o | output | 44 | Physical page number, with the offset bits of a large page filled in |
| rsp_size_o | output | 2 | Page size: 0 = 4 KB, 1 = 2 MB, 2 = 1 GB |
| rsp_attr_o | output | 10 | Low attribute bits of the final entry |

## Verification
A wrong level counter shows up on the second or third read address, as a wrong index field. It also shows as a wrong size code and a wrong count of reads on the response. A lost or stale table page number shows up at the very next read address, one handshake after the entry that supplied it. A slip in leaf detection or fault ordering shows up only on the response: the walk stops too early, runs past a leaf, or reports a page number where a fault was expected.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;
  localparam int unsigned PG_OFF_W = 12;
  localparam int unsigned ATTR_W   = 10;
  localparam int unsigned BIT_V    = 0;
  localparam int unsigned BIT_R    = 1;
  localparam int unsigned BIT_W    = 2;
  localparam int unsigned BIT_X    = 3;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_DONE
  } walk_state_e;
endpackage

// File: rtl/pt_index_addr.sv
module pt_index_addr
  import pt_walker_pkg::*;
#(
  parameter int unsigned LEVELS = 3,
  parameter int unsigned IDX_W  = 9,
  parameter int unsigned PA_W   = 56,
  localparam int unsigned VPN_W = LEVELS * IDX_W,
  localparam int unsigned PPN_W = PA_W - PG_OFF_W,
  localparam int unsigned LVL_W = $clog2(LEVELS)
) (
  input  logic [PPN_W-1:0] table_ppn_i,
  input  logic [VPN_W-1:0] vpn_i,
  input  logic [LVL_W-1:0] lvl_i,
  output logic [PA_W-1:0]  addr_o
);
  logic [IDX_W-1:0] idx;

  always_comb begin
    // level 0 takes the top index field
    idx    = IDX_W'(vpn_i >> (IDX_W * (LEVELS - 1 - 32'(lvl_i))));
    addr_o = {table_ppn_i, {PG_OFF_W{1'b0}}} + PA_W'({idx, 3'b000});
  end
endmodule

// File: rtl/pt_entry_decode.sv
module pt_entry_decode
  import pt_walker_pkg::*;
#(
  parameter int unsigned PTE_W  = 64,
  parameter int unsigned PPN_W  = 44
) (
  input  logic [PTE_W-1:0]  pte_i,
  output logic              valid_o,
  output logic              leaf_o,
  output logic [PPN_W-1:0]  ppn_o,
  output logic [ATTR_W-1:0] attr_o
);
  assign valid_o = pte_i[BIT_V];
  assign leaf_o  = pte_i[BIT_R] | pte_i[BIT_W] | pte_i[BIT_X];
  assign ppn_o   = pte_i[ATTR_W +: PPN_W];
  assign attr_o  = pte_i[ATTR_W-1:0];

  if (PTE_W > ATTR_W + PPN_W) begin : g_hi
    logic unused_hi;
    assign unused_hi = ^pte_i[PTE_W-1:ATTR_W+PPN_W];
  end
endmodule

// File: rtl/pt_leaf_merge.sv
module pt_leaf_merge #(
  parameter int unsigned LEVELS = 3,
  parameter int unsigned IDX_W  = 9,
  parameter int unsigned PPN_W  = 44,
  localparam int unsigned VPN_W = LEVELS * IDX_W,
  localparam int unsigned LVL_W = $clog2(LEVELS)
) (
  input  logic [PPN_W-1:0] pte_ppn_i,
  input  logic [VPN_W-1:0] vpn_i,
  input  logic [LVL_W-1:0] lvl_i,
  output logic [PPN_W-1:0] ppn_o
);
  logic [PPN_W-1:0] keep_mask;

  always_comb begin
    // low index fields below the leaf level come from the virtual address
    keep_mask = (PPN_W'(1) << (IDX_W * (LEVELS - 1 - 32'(lvl_i)))) - PPN_W'(1);
    ppn_o     = (pte_ppn_i & ~keep_mask) | (PPN_W'(vpn_i) & keep_mask);
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int unsigned LEVELS = 3,
  parameter int unsigned IDX_W  = 9,
  parameter int unsigned PA_W   = 56,
  parameter int unsigned PTE_W  = 64,
  localparam int unsigned VPN_W = LEVELS * IDX_W,
  localparam int unsigned VA_W  = VPN_W + PG_OFF_W,
  localparam int unsigned PPN_W = PA_W - PG_OFF_W,
  localparam int unsigned LVL_W = $clog2(LEVELS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [VA_W-1:0]   req_va_i,
  input  logic [PA_W-1:0]   base_i,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic [PA_W-1:0]   mem_req_addr_o,
  input  logic              mem_rsp_valid_i,
  output logic              mem_rsp_ready_o,
  input  logic [PTE_W-1:0]  mem_rsp_data_i,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic              rsp_fault_o,
  output logic [PPN_W-1:0]  rsp_ppn_o,
  output logic [LVL_W-1:0]  rsp_size_o,
  output logic [ATTR_W-1:0] rsp_attr_o
);
  localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LEVELS - 1);

  walk_state_e       state_q;
  logic [LVL_W-1:0]  lvl_q;
  logic [VPN_W-1:0]  vpn_q;
  logic [PPN_W-1:0]  table_ppn_q;
  logic              fault_q;
  logic [PPN_W-1:0]  ppn_q;
  logic [LVL_W-1:0]  size_q;
  logic [ATTR_W-1:0] attr_q;

  logic              pte_valid, pte_leaf;
  logic [PPN_W-1:0]  pte_ppn, leaf_ppn;
  logic [ATTR_W-1:0] pte_attr;
  logic [PG_OFF_W-1:0] unused_va_off;

  assign unused_va_off = req_va_i[PG_OFF_W-1:0];

  pt_index_addr #(.LEVELS(LEVELS), .IDX_W(IDX_W), .PA_W(PA_W)) u_addr (
    .table_ppn_i(table_ppn_q),
    .vpn_i      (vpn_q),
    .lvl_i      (lvl_q),
    .addr_o     (mem_req_addr_o)
  );

  pt_entry_decode #(.PTE_W(PTE_W), .PPN_W(PPN_W)) u_dec (
    .pte_i  (mem_rsp_data_i),
    .valid_o(pte_valid),
    .leaf_o (pte_leaf),
    .ppn_o  (pte_ppn),
    .attr_o (pte_attr)
  );

  pt_leaf_merge #(.LEVELS(LEVELS), .IDX_W(IDX_W), .PPN_W(PPN_W)) u_merge (
    .pte_ppn_i(pte_ppn),
    .vpn_i    (vpn_q),
    .lvl_i    (lvl_q),
    .ppn_o    (leaf_ppn)
  );

  assign req_ready_o     = (state_q == ST_IDLE);
  assign mem_req_valid_o = (state_q == ST_REQ);
  assign mem_rsp_ready_o = (state_q == ST_WAIT);
  assign rsp_valid_o     = (state_q == ST_DONE);
  assign rsp_fault_o     = fault_q;
  assign rsp_ppn_o       = ppn_q;
  assign rsp_size_o      = size_q;
  assign rsp_attr_o      = attr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      lvl_q       <= '0;
      vpn_q       <= '0;
      table_ppn_q <= '0;
      fault_q     <= 1'b0;
      ppn_q       <= '0;
      size_q      <= '0;
      attr_q      <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          vpn_q       <= req_va_i[VA_W-1:PG_OFF_W];
          table_ppn_q <= base_i[PA_W-1:PG_OFF_W];
          lvl_q       <= '0;
          state_q     <= ST_REQ;
        end
        ST_REQ: if (mem_req_ready_i) state_q <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid_i) begin
          attr_q <= pte_attr;
          if (!pte_valid || (!pte_leaf && lvl_q == LAST_LVL)) begin
            fault_q <= 1'b1;
            ppn_q   <= '0;
            size_q  <= '0;
            state_q <= ST_DONE;
          end else if (pte_leaf) begin
            fault_q <= 1'b0;
            ppn_q   <= leaf_ppn;
            size_q  <= LAST_LVL - lvl_q;
            state_q <= ST_DONE;
          end else begin
            table_ppn_q <= pte_ppn;
            lvl_q       <= lvl_q + LVL_W'(1);
            state_q     <= ST_REQ;
          end
        end
        ST_DONE: if (rsp_ready_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  a_r10_busy_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);

  a_r10_idle_after_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_ready_i) |=> (req_ready_o && !rsp_valid_o));

  a_r11_rsp_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_ready_i) |=> (rsp_valid_o && $stable(rsp_fault_o) &&
      $stable(rsp_ppn_o) && $stable(rsp_size_o) && $stable(rsp_attr_o)));

  a_r3_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && !mem_req_ready_i) |=> (mem_req_valid_o && $stable(mem_req_addr_o)));

  a_r3_one_outstanding: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && mem_req_ready_i) |=> (mem_rsp_ready_o && !mem_req_valid_o));

  a_r8_no_read_after_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !mem_req_valid_o);

  a_r5_size_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_fault_o) |-> (32'(rsp_size_o) < LEVELS));

  a_r8_fault_zero_ppn: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_fault_o) |-> (rsp_ppn_o == '0));
endmodule

// File: tb/tb_pt_walker.sv
module tb_pt_walker;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [38:0] req_va_i = '0;
  logic [55:0] base_i = 56'h1000 | 56'h5a3;
  logic        mem_req_valid_o;
  logic        mem_req_ready_i = 1'b0;
  logic [55:0] mem_req_addr_o;
  logic        mem_rsp_valid_i = 1'b0;
  logic        mem_rsp_ready_o;
  logic [63:0] mem_rsp_data_i = '0;
  logic        rsp_valid_o;
  logic        rsp_ready_i = 1'b0;
  logic        rsp_fault_o;
  logic [43:0] rsp_ppn_o;
  logic [1:0]  rsp_size_o;
  logic [9:0]  rsp_attr_o;

  int checks = 0;
  int failures = 0;
  int reads = 0;
  logic [55:0] addr_log [0:7];
  logic [63:0] mem [logic [55:0]];
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pt_walker dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o), .req_va_i(req_va_i), .base_i(base_i),
    .mem_req_valid_o(mem_req_valid_o), .mem_req_ready_i(mem_req_ready_i), .mem_req_addr_o(mem_req_addr_o),
    .mem_rsp_valid_i(mem_rsp_valid_i), .mem_rsp_ready_o(mem_rsp_ready_o), .mem_rsp_data_i(mem_rsp_data_i),
    .rsp_valid_o(rsp_valid_o), .rsp_ready_i(rsp_ready_i), .rsp_fault_o(rsp_fault_o),
    .rsp_ppn_o(rsp_ppn_o), .rsp_size_o(rsp_size_o), .rsp_attr_o(rsp_attr_o)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [55:0] ea(input int ppn, input int idx);
    return (56'(ppn) << 12) + 56'(idx) * 8;
  endfunction

  function automatic logic [63:0] pte(input logic [43:0] ppn, input logic [9:0] attr);
    return (64'(ppn) << 10) | 64'(attr);
  endfunction

  function automatic logic [38:0] mkva(input int i0, input int i1, input int i2, input int off);
    return {9'(i0), 9'(i1), 9'(i2), 12'(off)};
  endfunction

  // memory model: one read at a time, variable latency
  initial begin
    forever begin
      @(negedge clk);
      if (mem_req_valid_o) begin
        logic [55:0] a;
        a = mem_req_addr_o;
        mem_req_ready_i = 1'b1;
        if (reads < 8) addr_log[reads] = a;
        reads++;
        @(negedge clk);
        mem_req_ready_i = 1'b0;
        repeat (reads % 3) @(negedge clk);
        mem_rsp_valid_i = 1'b1;
        mem_rsp_data_i = mem.exists(a) ? mem[a] : 64'h0;
        @(negedge clk);
        mem_rsp_valid_i = 1'b0;
      end
    end
  end

  task automatic walk(input logic [38:0] va, input bit efault, input logic [43:0] eppn,
                      input logic [1:0] esize, input logic [9:0] eattr, input int ereads,
                      input bit hold, input string tag);
    int cyc;
    reads = 0;
    @(negedge clk);
    req_valid_i = 1'b1;
    req_va_i = va;
    @(negedge clk);
    check(req_ready_o == 1'b0, {tag, " R10 busy"}, 64'(req_ready_o), 64'd0);
    req_va_i = ~va;  // keep offering another request while busy
    cyc = 0;
    while (!rsp_valid_o && cyc < 400) begin
      @(negedge clk);
      cyc++;
    end
    req_valid_i = 1'b0;
    check(rsp_valid_o == 1'b1, {tag, " walk completes"}, 64'(rsp_valid_o), 64'd1);
    check(rsp_fault_o == efault, {tag, " fault flag"}, 64'(rsp_fault_o), 64'(efault));
    if (efault) check(rsp_ppn_o == '0, {tag, " R8 ppn zero"}, 64'(rsp_ppn_o), 64'd0);
    else begin
      check(rsp_ppn_o == eppn, {tag, " ppn"}, 64'(rsp_ppn_o), 64'(eppn));
      check(rsp_size_o == esize, {tag, " size"}, 64'(rsp_size_o), 64'(esize));
      check(rsp_attr_o == eattr, {tag, " R4 attr"}, 64'(rsp_attr_o), 64'(eattr));
    end
    check(reads == ereads, {tag, " R3 read count"}, 64'(reads), 64'(ereads));
    if (hold) begin
      logic [43:0] p;
      logic [1:0] s;
      logic f;
      p = rsp_ppn_o; s = rsp_size_o; f = rsp_fault_o;
      repeat (3) @(negedge clk);
      check(rsp_valid_o && rsp_ppn_o == p && rsp_size_o == s && rsp_fault_o == f,
            {tag, " R11 hold"}, 64'(rsp_ppn_o), 64'(p));
    end
    rsp_ready_i = 1'b1;
    @(negedge clk);
    rsp_ready_i = 1'b0;
    check(req_ready_o == 1'b1 && !rsp_valid_o, {tag, " R10 ready again"}, 64'(req_ready_o), 64'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // level 0 table at page 1, level 1 at page 2, level 2 at page 3
    mem[ea(1, 0)]  = pte(44'h2, 10'h001);
    mem[ea(1, 5)]  = pte(44'h40000, 10'h0cb);
    mem[ea(2, 0)]  = pte(44'h3, 10'h001);
    mem[ea(2, 7)]  = pte(44'h2200, 10'h005);
    for (int i = 0; i < 512; i++) begin
      if (i % 7 == 3) continue;
      if (i % 11 == 5) mem[ea(3, i)] = pte(44'h777, 10'h001);
      else mem[ea(3, i)] = pte(44'h100000 + 44'(i), {4'(i), 3'(i % 7 + 1), 1'b0, 1'b0, 1'b1} >> 2 | 10'(((i % 7 + 1) << 1) | 1) | 10'((i & 63) << 4));
    end

    #(CLK_PERIOD * 3);
    check(req_ready_o == 1'b1, "R1 ready at reset", 64'(req_ready_o), 64'd1);
    check(!mem_req_valid_o && !rsp_valid_o, "R1 idle outputs", 64'({mem_req_valid_o, rsp_valid_o}), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // R5 R9 R8 R12: third-level sweep with varying offsets
    for (int i = 0; i < 512; i++) begin
      bit f;
      logic [9:0] at;
      f = (i % 7 == 3) || (i % 11 == 5);
      at = 10'(((i % 7 + 1) << 1) | 1) | 10'((i & 63) << 4);
      walk(mkva(0, 0, i, (i * 13) & 12'hfff), f, 44'h100000 + 44'(i), 2'd0, at, 3, (i % 64 == 1),
           (i % 7 == 3) ? "R8 leaf-level invalid" : (i % 11 == 5) ? "R9 pointer at last level" : "R5 4K leaf");
      check(addr_log[0] == ea(1, 0), "R2 first read addr", 64'(addr_log[0]), 64'(ea(1, 0)));
      check(addr_log[1] == ea(2, 0), "R3 second read addr", 64'(addr_log[1]), 64'(ea(2, 0)));
      check(addr_log[2] == ea(3, i), "R3 third read addr", 64'(addr_log[2]), 64'(ea(3, i)));
    end

    // R7: 1 GB leaf at first level
    for (int k = 0; k < 24; k++) begin
      int i1, i2;
      i1 = (k * 37) % 512;
      i2 = (k * 101 + 3) % 512;
      walk(mkva(5, i1, i2, k * 170), 1'b0, 44'h40000 | 44'((i1 << 9) | i2), 2'd2, 10'h0cb, 1,
           (k == 4), "R7 1G leaf");
      check(addr_log[0] == ea(1, 5), "R2 first read addr 1G", 64'(addr_log[0]), 64'(ea(1, 5)));
    end

    // R6: 2 MB leaf at second level
    for (int k = 0; k < 24; k++) begin
      int i2;
      i2 = (k * 59 + 11) % 512;
      walk(mkva(0, 7, i2, 4095 - k), 1'b0, 44'h2200 | 44'(i2), 2'd1, 10'h005, 2, (k == 9), "R6 2M leaf");
      check(addr_log[1] == ea(2, 7), "R3 second read addr 2M", 64'(addr_log[1]), 64'(ea(2, 7)));
    end

    // R8: invalid entries at upper levels
    walk(mkva(9, 1, 2, 0), 1'b1, '0, 2'd0, 10'h0, 1, 1'b1, "R8 first-level invalid");
    walk(mkva(0, 12, 2, 0), 1'b1, '0, 2'd0, 10'h0, 2, 1'b0, "R8 second-level invalid");

    // R12: offset has no effect on result
    walk(mkva(0, 0, 1, 12'h000), 1'b0, 44'h100001, 2'd0, 10'h015 | 10'h015, 3, 1'b0, "R12 offset low");
    walk(mkva(0, 0, 1, 12'hfff), 1'b0, 44'h100001, 2'd0, 10'h015 | 10'h015, 3, 1'b0, "R12 offset high");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule